// File: doc/BRIEF.md
# Programmable Tick Timer

The block is a processor tick timer built from two software-visible registers: a count register that advances once per clock while the timer runs, and a control word that holds a match period, a two-bit mode, an interrupt enable and a sticky pending flag. Each counting cycle the block compares the incremented count with the period. The mode decides what a match does. The count can wrap back to zero, freeze at the period, or carry on incrementing.

A match with the enable set raises the pending flag. The flag stays set until software writes the control word. The interrupt output is the pending flag gated by a core-level timer-exception enable input. Software reaches both registers through one flat write/read port, and a select line picks the register. Reads are combinational.

Top module: `tick_timer`

## Requirements
- R1: While reset is asserted, and after it is released, the count reads 0, the control word reads 0 and the interrupt output is low.
- R2: With mode field (control bits [31:30]) equal to 00 the count does not change from cycle to cycle and reads back the value it last held.
- R3: With mode 01 (wrap) and period P>0, starting from count 0, the count after m counting cycles is m mod P. When the incremented count's low bits equal P the count returns to 0.
- R4: With mode 10 (single) the count stops at the period value on a match and stays there. A later control write with a nonzero mode starts it counting again from that value.
- R5: With mode 11 (free) a match leaves the count alone. The count keeps incrementing past the period.
- R6: A match while the enable bit (bit 29) is 1 sets the pending bit (bit 28), and the pending bit stays 1 while no control write occurs. A match with the enable bit 0 leaves the pending bit at 0.
- R7: Any control write clears the pending bit. Writing 1 to bit 28 never sets it.
- R8: The interrupt output is high exactly when the pending bit is 1 and the exception-enable input is high. The pending bit is kept regardless of that input.
- R9: A count write loads the written value in that cycle. Counting resumes from it on the following cycles.
- R10: The match compares only the low 28 bits of the count with the period. The full 32-bit count wraps from all-ones to 0.
- R11: A cycle that writes either register does not advance the count and cannot produce a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | Register select: 0 count, 1 control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| tmr_exc_en | input | 1 | Core-level timer exception enable |
| tick_irq | output | 1 | Level interrupt request |

## Verification
A wrong run flag or a wrong mode decode shows up on the count readback one clock later, as a value that sits off the arithmetic line m mod P, min(m,P) or m. A pending flag that is set or cleared at the wrong time shows on bit 28 and on the interrupt output in the cycle right after the matching edge. The period and mode are swept over small values, so an off-by-one in the compare moves the first wrap by one cycle and is seen within a few clocks.

// File: rtl/tick_pkg.sv
package tick_pkg;

  typedef enum logic [1:0] {
    TM_OFF     = 2'b00,
    TM_WRAP    = 2'b01,
    TM_SINGLE  = 2'b10,
    TM_FREE    = 2'b11
  } tick_mode_e;

endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/tick_ctrl_reg.sv
module tick_ctrl_reg
  import tick_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PER_W = DATA_W - 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  tick_mode_e       wr_mode,
  input  logic             wr_ie,
  input  logic [PER_W-1:0] wr_period,
  input  logic             match_evt,
  output tick_mode_e       mode,
  output logic             irq_en,
  output logic             pend,
  output logic [PER_W-1:0] period
);

  tick_mode_e       mode_q, mode_d;
  logic             ie_q, ie_d;
  logic             pend_q, pend_d;
  logic [PER_W-1:0] per_q, per_d;

  always_comb begin
    mode_d = mode_q;
    ie_d   = ie_q;
    per_d  = per_q;
    pend_d = pend_q;
    if (wr_en) begin
      mode_d = wr_mode;
      ie_d   = wr_ie;
      per_d  = wr_period;
      pend_d = 1'b0;
    end else if (match_evt && ie_q) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TM_OFF;
      ie_q   <= 1'b0;
      per_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ie_q   <= ie_d;
      per_q  <= per_d;
      pend_q <= pend_d;
    end
  end

  assign mode   = mode_q;
  assign irq_en = ie_q;
  assign pend   = pend_q;
  assign period = per_q;

  assert_pend_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && ie_q && !wr_en) |=> pend_q);
  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !wr_en) |=> pend_q);
  assert_pend_needs_ie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !ie_q) |=> !pend_q);
  assert_sw_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !pend_q);

endmodule

// File: rtl/tick_count_reg.sv
module tick_count_reg
  import tick_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PER_W = DATA_W - 4,
  localparam int PAD_W = DATA_W - PER_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              arm_en,
  input  logic [DATA_W-1:0] load_val,
  input  tick_mode_e        arm_mode,
  input  tick_mode_e        mode,
  input  logic [PER_W-1:0]  period,
  output logic [DATA_W-1:0] count,
  output logic              match_evt
);

  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              run_q, run_d;
  logic [DATA_W-1:0] cnt_inc;
  logic              hit;
  logic              step;

  assign cnt_inc   = cnt_q + 1'b1;
  assign hit       = (cnt_inc[PER_W-1:0] == period);
  assign step      = run_q && !load_en && !arm_en;
  assign match_evt = step && hit;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load_en) begin
      cnt_d = load_val;
    end else if (arm_en) begin
      run_d = (arm_mode != TM_OFF);
    end else if (step) begin
      case (mode)
        TM_WRAP:   cnt_d = hit ? '0 : cnt_inc;
        TM_SINGLE: begin
          if (hit) begin
            cnt_d = {{PAD_W{1'b0}}, period};
            run_d = 1'b0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        TM_FREE:   cnt_d = cnt_inc;
        default:   cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign count = cnt_q;

  assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_OFF && !load_en && !arm_en) |=> $stable(cnt_q));
  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode == TM_WRAP) |=> (cnt_q == '0));
  assert_single_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode == TM_SINGLE) |=> (!run_q && cnt_q[PER_W-1:0] == $past(period)));
  assert_free_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == TM_FREE) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt_q == $past(load_val)));
  assert_arm_no_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    arm_en |=> $stable(cnt_q));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int PER_W      = DATA_W - 4,
  localparam int MODE_HI    = DATA_W - 1,
  localparam int IE_BIT     = DATA_W - 3,
  localparam int PEND_BIT   = DATA_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tmr_exc_en,
  output logic              tick_irq
);

  logic              rst_int_n;
  logic              wr_cnt;
  logic              wr_ctl;
  tick_mode_e        new_mode;
  tick_mode_e        cur_mode;
  logic              cur_ie;
  logic              cur_pend;
  logic [PER_W-1:0]  cur_period;
  logic [DATA_W-1:0] cur_count;
  logic              match_evt;
  logic [DATA_W-1:0] ctl_word;

  tick_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign wr_cnt   = reg_wr && !reg_sel;
  assign wr_ctl   = reg_wr &&  reg_sel;
  assign new_mode = tick_mode_e'(reg_wdata[MODE_HI -: 2]);

  tick_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_ctl),
    .wr_mode   (new_mode),
    .wr_ie     (reg_wdata[IE_BIT]),
    .wr_period (reg_wdata[PER_W-1:0]),
    .match_evt (match_evt),
    .mode      (cur_mode),
    .irq_en    (cur_ie),
    .pend      (cur_pend),
    .period    (cur_period)
  );

  tick_count_reg #(.DATA_W(DATA_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_en   (wr_cnt),
    .arm_en    (wr_ctl),
    .load_val  (reg_wdata),
    .arm_mode  (new_mode),
    .mode      (cur_mode),
    .period    (cur_period),
    .count     (cur_count),
    .match_evt (match_evt)
  );

  assign ctl_word  = {cur_mode, cur_ie, cur_pend, cur_period};
  assign reg_rdata = reg_sel ? ctl_word : cur_count;
  assign tick_irq  = cur_pend && tmr_exc_en;

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !tmr_exc_en |-> !tick_irq);
  assert_irq_from_pend_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    tick_irq |-> ctl_word[PEND_BIT]);

endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        tmr_exc_en;
  logic        tick_irq;

  int total = 0;
  int bad   = 0;

  tick_timer uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .tmr_exc_en (tmr_exc_en),
    .tick_irq   (tick_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic [1:0] m, input logic ie, input logic pd, input logic [27:0] p);
    return {m, ie, pd, p};
  endfunction

  // call at a falling edge; returns at the next falling edge
  task automatic wr(input logic s, input logic [31:0] v);
    reg_sel   = s;
    reg_wdata = v;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    reg_sel = s;
    #0.5;
    v = reg_rdata;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] c;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0; tmr_exc_en = 1'b1;
    repeat (3) @(negedge clk);
    rd(1'b0, v); chk("R1 count in reset", v, 32'h0);
    rd(1'b1, v); chk("R1 ctl in reset", v, 32'h0);
    chk("R1 irq in reset", {31'h0, tick_irq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(1'b0, v); chk("R1 count after reset", v, 32'h0);
    rd(1'b1, v); chk("R1 ctl after reset", v, 32'h0);
    chk("R1 irq after reset", {31'h0, tick_irq}, 32'h0);
    @(negedge clk);

    // R2: off mode holds
    wr(1'b1, cw(2'b00, 1'b1, 1'b0, 28'd5));
    wr(1'b0, 32'h0000_1234);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rd(1'b0, v); chk("R2 off holds", v, 32'h0000_1234);
    end
    rd(1'b1, v); chk("R2 no pend when off", {31'h0, v[28]}, 32'h0);
    @(negedge clk);

    // sweeps over modes 01,10,11 and small periods
    for (int md = 1; md <= 3; md++) begin
      for (int p = 1; p <= 7; p++) begin
        logic ie;
        logic [31:0] ec;
        logic ep;
        ie = (p != 4);
        tmr_exc_en = p[0];
        wr(1'b1, 32'h0);
        wr(1'b0, 32'h0);
        wr(1'b1, cw(md[1:0], ie, 1'b0, p[27:0]));
        rd(1'b0, v); chk("R11 ctl write no step", v, 32'h0);
        for (int m = 1; m <= 3 * p + 1; m++) begin
          @(negedge clk);
          if (md == 1)      ec = m % p;
          else if (md == 2) ec = (m < p) ? m : p;
          else              ec = m;
          ep = ie && (m >= p);
          rd(1'b0, v);
          if (md == 1)      chk("R3 wrap count", v, ec);
          else if (md == 2) chk("R4 single count", v, ec);
          else              chk("R5 free count", v, ec);
          rd(1'b1, v); chk("R6 pend", {31'h0, v[28]}, {31'h0, ep});
          chk("R8 irq", {31'h0, tick_irq}, {31'h0, ep && tmr_exc_en});
        end
        @(negedge clk);
      end
    end

    // R4: rearm single mode restarts from the held value
    tmr_exc_en = 1'b1;
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h0);
    wr(1'b1, cw(2'b10, 1'b1, 1'b0, 28'd3));
    repeat (6) @(negedge clk);
    rd(1'b0, v); chk("R4 held at period", v, 32'd3);
    @(negedge clk);
    wr(1'b1, cw(2'b10, 1'b1, 1'b0, 28'd6));
    rd(1'b1, v); chk("R7 write clears pend", {31'h0, v[28]}, 32'h0);
    chk("R7 irq cleared", {31'h0, tick_irq}, 32'h0);
    for (int m = 1; m <= 5; m++) begin
      @(negedge clk);
      c = (3 + m < 6) ? 3 + m : 6;
      rd(1'b0, v); chk("R4 rearm count", v, c);
    end
    rd(1'b1, v); chk("R6 pend after rearm match", {31'h0, v[28]}, 32'h1);

    // R8: pending survives while exception enable is low
    @(negedge clk);
    tmr_exc_en = 1'b0;
    #0.5;
    chk("R8 irq gated off", {31'h0, tick_irq}, 32'h0);
    rd(1'b1, v); chk("R8 pend kept", {31'h0, v[28]}, 32'h1);
    @(negedge clk);
    tmr_exc_en = 1'b1;
    #0.5;
    chk("R8 irq back on", {31'h0, tick_irq}, 32'h1);
    @(negedge clk);

    // R7: writing 1 to pending never sets it
    wr(1'b1, cw(2'b00, 1'b1, 1'b1, 28'd9));
    rd(1'b1, v); chk("R7 sw cannot set pend", {31'h0, v[28]}, 32'h0);
    chk("R7 irq low", {31'h0, tick_irq}, 32'h0);
    @(negedge clk);

    // R9/R10: load with upper bits set, match on low 28 bits
    wr(1'b1, cw(2'b11, 1'b1, 1'b0, 28'd5));
    wr(1'b0, 32'h3000_0002);
    rd(1'b0, v); chk("R9 load exact", v, 32'h3000_0002);
    rd(1'b1, v); chk("R10 no pend yet", {31'h0, v[28]}, 32'h0);
    @(negedge clk);
    @(negedge clk);
    rd(1'b1, v); chk("R10 no pend before match", {31'h0, v[28]}, 32'h0);
    @(negedge clk);
    rd(1'b0, v); chk("R9 resumes from load", v, 32'h3000_0005);
    rd(1'b1, v); chk("R10 low-bit match", {31'h0, v[28]}, 32'h1);
    @(negedge clk);

    // R10: full wrap
    wr(1'b1, cw(2'b11, 1'b0, 1'b0, 28'h100));
    wr(1'b0, 32'hFFFF_FFFE);
    @(negedge clk);
    rd(1'b0, v); chk("R10 near top", v, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(1'b0, v); chk("R10 wraps to zero", v, 32'h0);
    rd(1'b1, v); chk("R6 no pend with ie off", {31'h0, v[28]}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule